// File: doc/BRIEF.md
# Integer ALU with Condition Flags

This block is a purely combinational arithmetic and logic unit. It receives two operands of a configurable width and a four-bit operation code. It returns a result of the same width, a result-valid qualifier and four condition flags: zero, negative, carry and overflow. The operands come from a register read port or an immediate path outside the block. The ALU stores nothing itself.

The unit supports the following operations:

- addition and subtraction;
- bitwise AND, OR and XOR;
- logical left shift;
- logical right shift, which fills with zeros;
- arithmetic right shift, which fills with the sign bit;
- a compare operation, which produces flags only.

For the shifts, only the low log2(XLEN) bits of the second operand give the shift distance. Codes that name no operation produce a zero result with every flag cleared.

The block has no state machine. Its single decode step maps the operation code to one datapath branch. The branches are ADD, SUB, AND, OR, XOR, SLL, SRL, SRA, CMP and the idle branch taken for unused codes. The choice between branches is made fresh on every input change.

Top module: `alu_core`

## Requirements
- R1: Code 0 (add) gives result = A + B modulo 2^XLEN. C is the carry out of the top bit. V is set when A and B share a sign and the result's sign differs from it.
- R2: Code 1 (subtract) gives result = A - B modulo 2^XLEN. C is the carry out of A + ~B + 1, so C = 1 exactly when A >= B unsigned. V is set when the signs of A and B differ and the result's sign differs from A's sign.
- R3: Codes 2 (AND), 3 (OR) and 4 (XOR) give the bitwise function of A and B, with C = 0 and V = 0.
- R4: Code 5 shifts A left by B[log2(XLEN)-1:0] and fills with zeros. Higher bits of B have no effect. C = 0 and V = 0.
- R5: Code 6 shifts A right by B[log2(XLEN)-1:0] and fills the vacated high bits with zeros. C = 0 and V = 0.
- R6: Code 7 shifts A right by B[log2(XLEN)-1:0] and fills the vacated high bits with copies of A[XLEN-1]. C = 0 and V = 0.
- R7: For codes 0 to 7, Z is 1 exactly when the result is all zeros, and N equals result[XLEN-1].
- R8: Code 8 (compare) sets Z, N, C and V as subtraction would for A - B. It drives a zero result and holds result-valid low.
- R9: Codes 9 to 15 give a zero result, result-valid low and all four flags 0.
- R10: Result-valid is 1 for codes 0 to 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_a | input | XLEN | First operand |
| opnd_b | input | XLEN | Second operand; its low log2(XLEN) bits give the shift distance |
| op_sel | input | 4 | Operation code |
| result | output | XLEN | Operation result |
| res_valid | output | 1 | High when result carries a value |
| flag_z | output | 1 | Zero flag |
| flag_n | output | 1 | Negative flag |
| flag_c | output | 1 | Carry flag |
| flag_v | output | 1 | Signed overflow flag |

## Verification
The bench drives edge operands through every operation. These include 0x7FFFFFFF + 1, 0x80000000 - 1, 0 - 1 and equal operands. A carry or overflow rule with a wrong sign term shows up there as a flipped C or V.

Shift distances of 0, 1 and 31, and distances with high bits set in B, expose a design that leaves B unmasked or fills with the wrong bit. Such a design zeroes the result or smears the sign into a logical shift.

Compare and the unused codes check that no result leaks out and that no flag is left stale. Random operands cover the rest.

// File: rtl/alu_pkg.sv
package alu_pkg;

    typedef enum logic [3:0] {
        OP_ADD = 4'd0,
        OP_SUB = 4'd1,
        OP_AND = 4'd2,
        OP_OR  = 4'd3,
        OP_XOR = 4'd4,
        OP_SLL = 4'd5,
        OP_SRL = 4'd6,
        OP_SRA = 4'd7,
        OP_CMP = 4'd8
    } alu_op_e;

    typedef enum logic [1:0] {
        BW_AND = 2'd0,
        BW_OR  = 2'd1,
        BW_XOR = 2'd2
    } bitwise_e;

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    input  logic            subtract,
    output logic [XLEN-1:0] sum,
    output logic            carry,
    output logic            overflow
);
    logic [XLEN-1:0] b_eff;
    logic [XLEN:0]   wide;

    always_comb begin
        b_eff    = subtract ? ~b : b;
        wide     = {1'b0, a} + {1'b0, b_eff} + {{XLEN{1'b0}}, subtract};
        sum      = wide[XLEN-1:0];
        carry    = wide[XLEN];
        overflow = (a[XLEN-1] == b_eff[XLEN-1]) && (sum[XLEN-1] != a[XLEN-1]);
    end
endmodule

// File: rtl/alu_bitwise.sv
module alu_bitwise #(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0]         a,
    input  logic [XLEN-1:0]         b,
    input  alu_pkg::bitwise_e       fn,
    output logic [XLEN-1:0]         y
);
    always_comb begin
        unique case (fn)
            alu_pkg::BW_AND: y = a & b;
            alu_pkg::BW_OR:  y = a | b;
            alu_pkg::BW_XOR: y = a ^ b;
            default:         y = '0;
        endcase
    end
endmodule

// File: rtl/alu_shifter.sv
module alu_shifter #(
    parameter int XLEN = 32,
    localparam int SHW = $clog2(XLEN)
) (
    input  logic [XLEN-1:0] a,
    input  logic [SHW-1:0]  amount,
    input  logic            to_left,
    input  logic            arith,
    output logic [XLEN-1:0] y
);
    logic [XLEN-1:0] stage [0:SHW];
    logic [XLEN-1:0] in_rev;
    logic [XLEN-1:0] out_rev;
    logic            fill;

    always_comb begin
        for (int i = 0; i < XLEN; i++) begin
            in_rev[i] = a[XLEN-1-i];
        end
    end

    assign fill     = arith & ~to_left & a[XLEN-1];
    assign stage[0] = to_left ? in_rev : a;

    for (genvar g = 0; g < SHW; g++) begin : g_stage
        assign stage[g+1] = amount[g]
            ? {{(2**g){fill}}, stage[g][XLEN-1:2**g]}
            : stage[g];
    end

    always_comb begin
        for (int i = 0; i < XLEN; i++) begin
            out_rev[i] = stage[SHW][XLEN-1-i];
        end
    end

    assign y = to_left ? out_rev : stage[SHW];
endmodule

// File: rtl/alu_core.sv
module alu_core #(
    parameter int XLEN = 32,
    localparam int SHW = $clog2(XLEN)
) (
    input  logic [XLEN-1:0] opnd_a,
    input  logic [XLEN-1:0] opnd_b,
    input  logic [3:0]      op_sel,
    output logic [XLEN-1:0] result,
    output logic            res_valid,
    output logic            flag_z,
    output logic            flag_n,
    output logic            flag_c,
    output logic            flag_v
);
    import alu_pkg::*;

    alu_op_e         op;
    logic            sub_mode;
    logic [XLEN-1:0] as_sum;
    logic            as_carry;
    logic            as_ovf;
    bitwise_e        bw_fn;
    logic [XLEN-1:0] bw_y;
    logic [XLEN-1:0] sh_y;

    assign op       = alu_op_e'(op_sel);
    assign sub_mode = (op == OP_SUB) || (op == OP_CMP);

    always_comb begin
        unique case (op)
            OP_OR:   bw_fn = BW_OR;
            OP_XOR:  bw_fn = BW_XOR;
            default: bw_fn = BW_AND;
        endcase
    end

    alu_addsub #(.XLEN(XLEN)) u_addsub (
        .a(opnd_a), .b(opnd_b), .subtract(sub_mode),
        .sum(as_sum), .carry(as_carry), .overflow(as_ovf)
    );

    alu_bitwise #(.XLEN(XLEN)) u_bitwise (
        .a(opnd_a), .b(opnd_b), .fn(bw_fn), .y(bw_y)
    );

    alu_shifter #(.XLEN(XLEN)) u_shifter (
        .a(opnd_a), .amount(opnd_b[SHW-1:0]),
        .to_left(op == OP_SLL), .arith(op == OP_SRA), .y(sh_y)
    );

    // Output decode: one branch per operation, idle branch for unused codes
    always_comb begin
        result    = '0;
        res_valid = 1'b0;
        flag_z    = 1'b0;
        flag_n    = 1'b0;
        flag_c    = 1'b0;
        flag_v    = 1'b0;
        unique case (op)
            OP_ADD, OP_SUB: begin
                result    = as_sum;
                res_valid = 1'b1;
                flag_z    = (as_sum == '0);
                flag_n    = as_sum[XLEN-1];
                flag_c    = as_carry;
                flag_v    = as_ovf;
            end
            OP_AND, OP_OR, OP_XOR: begin
                result    = bw_y;
                res_valid = 1'b1;
                flag_z    = (bw_y == '0);
                flag_n    = bw_y[XLEN-1];
            end
            OP_SLL, OP_SRL, OP_SRA: begin
                result    = sh_y;
                res_valid = 1'b1;
                flag_z    = (sh_y == '0);
                flag_n    = sh_y[XLEN-1];
            end
            OP_CMP: begin
                flag_z    = (as_sum == '0);
                flag_n    = as_sum[XLEN-1];
                flag_c    = as_carry;
                flag_v    = as_ovf;
            end
            default: ;
        endcase
    end

    // Checks placed beside the decode they guard
    always_comb begin
        if (op_sel == 4'd6 && opnd_b[SHW-1:0] != '0)
            assert_srl_zero_fill_R5: assert (result[XLEN-1] == 1'b0);
        if (op_sel == 4'd7)
            assert_sra_sign_fill_R6: assert (result[XLEN-1] == opnd_a[XLEN-1]);
        if (op_sel >= 4'd2 && op_sel <= 4'd7)
            assert_no_carry_ovf_R3: assert (!flag_c && !flag_v);
        if (op_sel == 4'd8)
            assert_cmp_no_result_R8: assert (!res_valid && result == '0);
        if (op_sel > 4'd8)
            assert_unused_idle_R9: assert (!res_valid && !flag_z && !flag_n && !flag_c && !flag_v);
        if (res_valid)
            assert_zero_flag_R7: assert (flag_z == (result == '0));
    end
endmodule

// File: tb/alu_core_test.sv
module alu_core_test;
    localparam int W = 32;

    typedef struct {
        logic [3:0]   op;
        logic [W-1:0] a;
        logic [W-1:0] b;
        logic [W-1:0] res;
        logic         vld;
        logic         z, n, c, v;
    } item_t;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] opnd_a = '0;
    logic [W-1:0] opnd_b = '0;
    logic [3:0]   op_sel = 4'd15;
    logic [W-1:0] result;
    logic         res_valid, flag_z, flag_n, flag_c, flag_v;

    int     n_checks = 0;
    int     n_fail = 0;
    bit     done = 1'b0;
    item_t  sb_q[$];

    always #5 clk = ~clk;

    alu_core #(.XLEN(W)) uut (
        .opnd_a(opnd_a), .opnd_b(opnd_b), .op_sel(op_sel), .result(result),
        .res_valid(res_valid), .flag_z(flag_z), .flag_n(flag_n),
        .flag_c(flag_c), .flag_v(flag_v)
    );

    function automatic item_t model(logic [3:0] op, logic [W-1:0] a, logic [W-1:0] b);
        item_t e;
        logic signed [W:0] s;
        int sh;
        e.op = op; e.a = a; e.b = b;
        e.res = '0; e.vld = 1'b0; e.z = 1'b0; e.n = 1'b0; e.c = 1'b0; e.v = 1'b0;
        sh = int'(b[4:0]);
        case (op)
            4'd0: begin
                e.res = a + b;
                e.c = ({1'b0, a} + {1'b0, b}) > 33'h0_FFFF_FFFF;
                s = $signed({a[W-1], a}) + $signed({b[W-1], b});
                e.v = (s > 33'sh0_7FFF_FFFF) || (s < -33'sh0_8000_0000);
            end
            4'd1, 4'd8: begin
                e.res = a - b;
                e.c = (a >= b);
                s = $signed({a[W-1], a}) - $signed({b[W-1], b});
                e.v = (s > 33'sh0_7FFF_FFFF) || (s < -33'sh0_8000_0000);
            end
            4'd2: e.res = a & b;
            4'd3: e.res = a | b;
            4'd4: e.res = a ^ b;
            4'd5: e.res = a << sh;
            4'd6: e.res = a >> sh;
            4'd7: e.res = $unsigned($signed(a) >>> sh);
            default: ;
        endcase
        if (op <= 4'd8) begin
            e.z = (e.res == '0);
            e.n = e.res[W-1];
        end
        if (op == 4'd8) e.res = '0;
        e.vld = (op <= 4'd7);
        return e;
    endfunction

    function automatic string op_tag(logic [3:0] op);
        case (op)
            4'd0: return "R1";
            4'd1: return "R2";
            4'd2, 4'd3, 4'd4: return "R3";
            4'd5: return "R4";
            4'd6: return "R5";
            4'd7: return "R6";
            4'd8: return "R8";
            default: return "R9";
        endcase
    endfunction

    task automatic drive(logic [3:0] op, logic [W-1:0] a, logic [W-1:0] b);
        @(negedge clk);
        op_sel = op; opnd_a = a; opnd_b = b;
        sb_q.push_back(model(op, a, b));
    endtask

    // Monitor: pops the item driven on the previous falling edge
    always @(posedge clk) begin
        if (!rst && sb_q.size() > 0) begin
            item_t e;
            string t;
            e = sb_q.pop_front();
            n_checks++;
            t = op_tag(e.op);
            if (result !== e.res || flag_c !== e.c || flag_v !== e.v) begin
                n_fail++;
                $display("FAIL %s op=%0d a=%h b=%h: res=%h c=%b v=%b, expected res=%h c=%b v=%b",
                         t, e.op, e.a, e.b, result, flag_c, flag_v, e.res, e.c, e.v);
            end else if (flag_z !== e.z || flag_n !== e.n) begin
                n_fail++;
                $display("FAIL %s op=%0d a=%h b=%h: z=%b n=%b, expected z=%b n=%b",
                         (e.op <= 4'd7) ? "R7" : t, e.op, e.a, e.b, flag_z, flag_n, e.z, e.n);
            end else if (res_valid !== e.vld) begin
                n_fail++;
                $display("FAIL %s op=%0d: valid=%b, expected %b",
                         (e.op <= 4'd7) ? "R10" : t, e.op, res_valid, e.vld);
            end
        end
    end

    initial begin
        #1_000_000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired: got hang, expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (2) @(posedge clk);
        rst = 1'b0;
        // Idle state right after reset (unused code 15): R9
        drive(4'd15, 32'hFFFF_FFFF, 32'h1234_5678);
        // R1 add corners
        drive(4'd0, 32'h7FFF_FFFF, 32'h1);
        drive(4'd0, 32'hFFFF_FFFF, 32'h1);
        drive(4'd0, 32'h8000_0000, 32'h8000_0000);
        drive(4'd0, 32'h0, 32'h0);
        // R2 subtract corners
        drive(4'd1, 32'h8000_0000, 32'h1);
        drive(4'd1, 32'h0, 32'h1);
        drive(4'd1, 32'h5, 32'h5);
        drive(4'd1, 32'h7FFF_FFFF, 32'hFFFF_FFFF);
        // R3 bitwise
        drive(4'd2, 32'hF0F0_F0F0, 32'h0F0F_0F0F);
        drive(4'd3, 32'hF0F0_0000, 32'h0000_0F0F);
        drive(4'd4, 32'hAAAA_AAAA, 32'hAAAA_AAAA);
        // R4 left shift, masking of high bits of B
        drive(4'd5, 32'h0000_0001, 32'd31);
        drive(4'd5, 32'h8000_0001, 32'h0000_0020);
        drive(4'd5, 32'h0000_00FF, 32'hFFFF_FFE4);
        // R5 logical right
        drive(4'd6, 32'h8000_0000, 32'd31);
        drive(4'd6, 32'h8A00_0000, 32'd2);
        drive(4'd6, 32'hDEAD_BEEF, 32'd0);
        // R6 arithmetic right
        drive(4'd7, 32'h8A00_0000, 32'd2);
        drive(4'd7, 32'h8000_0000, 32'd31);
        drive(4'd7, 32'h7000_0000, 32'h0000_0041);
        // R8 compare
        drive(4'd8, 32'h5, 32'h5);
        drive(4'd8, 32'h1, 32'h2);
        drive(4'd8, 32'h8000_0000, 32'h1);
        // R9 unused codes
        for (int k = 9; k < 16; k++) drive(4'(k), 32'h0, 32'h0);
        // Random mix over all codes (R7, R10 exercised throughout)
        for (int k = 0; k < 400; k++) drive(4'($urandom_range(0, 15)), $urandom, $urandom);
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule